// File: doc/BRIEF.md
# Shared Transmit/Receive Frame Buffer

This block owns a 128-byte frame store that a low-power radio uses for both directions, one at a time. A host byte port loads an outgoing frame and reads back an incoming one. Each access is either a single byte at a fixed address or part of a burst in which the address steps by one after every access. The receive path writes each incoming byte, appends a link-quality byte after the last one, and records the byte count in a length register that sits outside the store. A separate read port feeds the outgoing frame to the modulator.

Outgoing frames follow a fixed layout: the length byte sits at address 0 and the payload follows it. Incoming payload uses the same offsets, so its first byte lands at address 1. A protect level keeps incoming frames from overwriting the store, and host loads still go through while it is set. Two sticky flags report errors. The under-run flag covers a read beyond valid data, and the drop flag covers a receive byte lost to a host write in the same cycle.

Top module: `pkt_buf_ctrl`

## Requirements
- R1: After reset, rx_len_o, undr_o and rx_drop_o are all 0 and host_rdata_o is 0.
- R2: A host access uses host_addr_i when host_start_i is high and the held pointer otherwise. With host_burst_i low the pointer stays put, so a following access without host_start_i reuses the same address. Read data appears on host_rdata_o in the cycle after host_rd_i and is the content from before any write in that same cycle.
- R3: With host_burst_i high, each host access advances the pointer by one and 127 wraps to 0, so all 128 bytes can be written or read in a single burst.
- R4: rx_sof_i points the receive writer at address 1 with a count of 0. Each rx_byte_vld_i stores rx_byte_i at the current receive address, then advances the address (wrapping) and the count.
- R5: rx_eof_i stores rx_lqi_i at frame length + 1 and loads the frame byte count into rx_len_o in the next cycle. A 127-byte frame puts its link-quality byte at address 0. rx_len_o changes on no other input.
- R6: While rx_prot_i is high, receive bytes, the link-quality byte and the length register are all left untouched, while host writes still land.
- R7: When a host write and an unprotected receive write fall in the same cycle, the host write is stored and the receive write is lost. rx_drop_o then goes to 1 in the next cycle and stays there.
- R8: tx_rd_i returns the byte at tx_addr_i on tx_rdata_o in the next cycle.
- R9: A tx_rd_i whose tx_addr_i is greater than the byte last written at address 0 (by either writer) sets undr_o in the next cycle. Addresses up to and including that value do not set it.
- R10: Once a frame has been received, a host burst read at an address greater than rx_len_o + 1 sets undr_o. Single-byte reads never set it.
- R11: undr_o and rx_drop_o stay at 1 until err_clr_i. The clear takes effect in the next cycle, and a new set in the same cycle as a clear wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| host_start_i | input | 1 | Use host_addr_i for this access and reload the pointer |
| host_addr_i | input | 7 | Host start address |
| host_burst_i | input | 1 | Advance the pointer after this access |
| host_wr_i | input | 1 | Host write strobe |
| host_wdata_i | input | 8 | Host write byte |
| host_rd_i | input | 1 | Host read strobe |
| host_rdata_o | output | 8 | Host read byte, one cycle after the strobe |
| rx_sof_i | input | 1 | Receive frame start |
| rx_byte_vld_i | input | 1 | Receive byte strobe |
| rx_byte_i | input | 8 | Receive byte |
| rx_eof_i | input | 1 | Receive frame end, with link-quality byte |
| rx_lqi_i | input | 8 | Link-quality byte |
| rx_prot_i | input | 1 | Block receive writes |
| rx_len_o | output | 8 | Last received frame length |
| tx_rd_i | input | 1 | Transmit read strobe |
| tx_addr_i | input | 7 | Transmit read address |
| tx_rdata_o | output | 8 | Transmit read byte, one cycle after the strobe |
| err_clr_i | input | 1 | Clear both sticky flags |
| undr_o | output | 1 | Sticky under-run flag |
| rx_drop_o | output | 1 | Sticky dropped-receive flag |

## Verification
The store is exercised with several access patterns, and each one separates behaviours that a simpler pattern would let pass. Single-byte accesses show whether the pointer holds. A wrapping burst and a full 128-byte burst show the increment and the wrap. A short received frame checks the payload offset and where the link-quality byte lands. A 127-byte frame pushes that byte around to address 0, which then changes the transmit length used by the under-run check. Protected frames, a receive byte that collides with a host write, and reads just inside and just outside the valid range separate the blocking, arbitration and under-run rules. A behavioural reference model compares every output after each clock.

// File: rtl/pb_pkg.sv
package pb_pkg;
  typedef enum logic [1:0] {WSRC_NONE, WSRC_HOST, WSRC_RX} wsrc_e;
endpackage

// File: rtl/pb_ram.sv
module pb_ram #(
  parameter int DEPTH = 128,
  parameter int DW    = 8,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          re_a_i,
  input  logic [AW-1:0] raddr_a_i,
  output logic [DW-1:0] rdata_a_o,
  input  logic          re_b_i,
  input  logic [AW-1:0] raddr_b_i,
  output logic [DW-1:0] rdata_b_o
);
  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  // read-before-write on both ports
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_a_o <= '0;
      rdata_b_o <= '0;
    end else begin
      if (re_a_i) rdata_a_o <= mem_q[raddr_a_i];
      if (re_b_i) rdata_b_o <= mem_q[raddr_b_i];
    end
  end
endmodule

// File: rtl/pb_host_ptr.sv
module pb_host_ptr #(
  parameter int AW = 7
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [AW-1:0] addr_i,
  input  logic          burst_i,
  input  logic          acc_i,
  output logic [AW-1:0] eff_addr_o
);
  logic [AW-1:0] ptr_q;

  assign eff_addr_o = start_i ? addr_i : ptr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             ptr_q <= '0;
    else if (acc_i && burst_i) ptr_q <= eff_addr_o + AW'(1);  // wraps at top
    else if (start_i)        ptr_q <= addr_i;
  end
endmodule

// File: rtl/pb_rx_wr.sv
module pb_rx_wr #(
  parameter int AW = 7,
  parameter int DW = 8,
  parameter int LW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          sof_i,
  input  logic          byte_vld_i,
  input  logic [DW-1:0] byte_i,
  input  logic          eof_i,
  input  logic [DW-1:0] lqi_i,
  input  logic          prot_i,
  output logic          req_o,
  output logic [AW-1:0] addr_o,
  output logic [DW-1:0] data_o,
  output logic [LW-1:0] len_o,
  output logic          seen_o
);
  logic [AW-1:0] ptr_q;
  logic [LW-1:0] cnt_q, cnt_eff;

  // payload starts at 1 to mirror the transmit layout
  assign addr_o  = sof_i ? AW'(1) : ptr_q;
  assign cnt_eff = sof_i ? '0 : cnt_q;
  assign req_o   = (byte_vld_i || eof_i) && !prot_i;
  assign data_o  = eof_i ? lqi_i : byte_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q  <= '0;
      cnt_q  <= '0;
      len_o  <= '0;
      seen_o <= 1'b0;
    end else if (eof_i) begin
      ptr_q <= addr_o;
      cnt_q <= cnt_eff;
      if (!prot_i) begin
        len_o  <= cnt_eff;
        seen_o <= 1'b1;
      end
    end else if (byte_vld_i) begin
      ptr_q <= addr_o + AW'(1);
      cnt_q <= cnt_eff + LW'(1);
    end else if (sof_i) begin
      ptr_q <= AW'(1);
      cnt_q <= '0;
    end
  end
endmodule

// File: rtl/pb_flags.sv
module pb_flags #(
  parameter int AW = 7,
  parameter int DW = 8,
  parameter int LW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tx_rd_i,
  input  logic [AW-1:0] tx_addr_i,
  input  logic [DW-1:0] tx_len_i,
  input  logic          host_rd_i,
  input  logic          host_burst_i,
  input  logic [AW-1:0] host_addr_i,
  input  logic [LW-1:0] rx_len_i,
  input  logic          rx_seen_i,
  input  logic          host_wr_i,
  input  logic          rx_req_i,
  input  logic          clr_i,
  output logic          undr_o,
  output logic          drop_o
);
  localparam int CW = ((DW > AW) ? ((DW > LW) ? DW : LW) : ((AW > LW) ? AW : LW)) + 1;

  logic [CW-1:0] tx_a, tx_lim, h_a, h_lim;
  logic          tx_undr, h_undr, drop_set;

  assign tx_a     = CW'(tx_addr_i);
  assign tx_lim   = CW'(tx_len_i);
  assign h_a      = CW'(host_addr_i);
  assign h_lim    = CW'(rx_len_i) + CW'(1);
  assign tx_undr  = tx_rd_i && (tx_a > tx_lim);
  assign h_undr   = host_rd_i && host_burst_i && rx_seen_i && (h_a > h_lim);
  assign drop_set = host_wr_i && rx_req_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      undr_o <= 1'b0;
      drop_o <= 1'b0;
    end else begin
      if (tx_undr || h_undr) undr_o <= 1'b1;
      else if (clr_i)        undr_o <= 1'b0;
      if (drop_set)          drop_o <= 1'b1;
      else if (clr_i)        drop_o <= 1'b0;
    end
  end
endmodule

// File: rtl/pkt_buf_ctrl.sv
module pkt_buf_ctrl #(
  parameter int DEPTH = 128,
  parameter int DW    = 8,
  localparam int AW   = $clog2(DEPTH),
  localparam int LW   = AW + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          host_start_i,
  input  logic [AW-1:0] host_addr_i,
  input  logic          host_burst_i,
  input  logic          host_wr_i,
  input  logic [DW-1:0] host_wdata_i,
  input  logic          host_rd_i,
  output logic [DW-1:0] host_rdata_o,
  input  logic          rx_sof_i,
  input  logic          rx_byte_vld_i,
  input  logic [DW-1:0] rx_byte_i,
  input  logic          rx_eof_i,
  input  logic [DW-1:0] rx_lqi_i,
  input  logic          rx_prot_i,
  output logic [LW-1:0] rx_len_o,
  input  logic          tx_rd_i,
  input  logic [AW-1:0] tx_addr_i,
  output logic [DW-1:0] tx_rdata_o,
  input  logic          err_clr_i,
  output logic          undr_o,
  output logic          rx_drop_o
);
  import pb_pkg::*;

  logic [AW-1:0] h_addr, rx_addr, waddr;
  logic [DW-1:0] rx_data, wdata, len0_q;
  logic          rx_req, rx_seen, we;
  wsrc_e         wsrc;

  pb_host_ptr #(.AW(AW)) u_hptr (
    .clk_i, .rst_ni,
    .start_i(host_start_i), .addr_i(host_addr_i), .burst_i(host_burst_i),
    .acc_i(host_rd_i || host_wr_i), .eff_addr_o(h_addr)
  );

  pb_rx_wr #(.AW(AW), .DW(DW), .LW(LW)) u_rx (
    .clk_i, .rst_ni,
    .sof_i(rx_sof_i), .byte_vld_i(rx_byte_vld_i), .byte_i(rx_byte_i),
    .eof_i(rx_eof_i), .lqi_i(rx_lqi_i), .prot_i(rx_prot_i),
    .req_o(rx_req), .addr_o(rx_addr), .data_o(rx_data),
    .len_o(rx_len_o), .seen_o(rx_seen)
  );

  // host beats receive
  always_comb begin
    if (host_wr_i)   wsrc = WSRC_HOST;
    else if (rx_req) wsrc = WSRC_RX;
    else             wsrc = WSRC_NONE;
    unique case (wsrc)
      WSRC_HOST: begin we = 1'b1; waddr = h_addr;  wdata = host_wdata_i; end
      WSRC_RX:   begin we = 1'b1; waddr = rx_addr; wdata = rx_data;      end
      default:   begin we = 1'b0; waddr = '0;      wdata = '0;           end
    endcase
  end

  // shadow of address 0 for the transmit length check
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  len0_q <= '0;
    else if (we && waddr == '0)   len0_q <= wdata;
  end

  pb_ram #(.DEPTH(DEPTH), .DW(DW)) u_ram (
    .clk_i, .rst_ni,
    .we_i(we), .waddr_i(waddr), .wdata_i(wdata),
    .re_a_i(host_rd_i), .raddr_a_i(h_addr), .rdata_a_o(host_rdata_o),
    .re_b_i(tx_rd_i), .raddr_b_i(tx_addr_i), .rdata_b_o(tx_rdata_o)
  );

  pb_flags #(.AW(AW), .DW(DW), .LW(LW)) u_flags (
    .clk_i, .rst_ni,
    .tx_rd_i, .tx_addr_i, .tx_len_i(len0_q),
    .host_rd_i, .host_burst_i, .host_addr_i(h_addr),
    .rx_len_i(rx_len_o), .rx_seen_i(rx_seen),
    .host_wr_i, .rx_req_i(rx_req), .clr_i(err_clr_i),
    .undr_o, .drop_o(rx_drop_o)
  );
endmodule

// File: rtl/pb_chk.sv
module pb_chk #(
  parameter int LW = 8
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          host_wr_i,
  input logic          host_rd_i,
  input logic          rx_byte_vld_i,
  input logic          rx_eof_i,
  input logic          rx_prot_i,
  input logic          tx_rd_i,
  input logic          err_clr_i,
  input logic [LW-1:0] rx_len_o,
  input logic          undr_o,
  input logic          rx_drop_o
);
  // R11
  undr_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    undr_o && !err_clr_i |=> undr_o);
  // R11
  undr_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_clr_i && !tx_rd_i && !host_rd_i |=> !undr_o);
  // R7
  drop_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_drop_o && !err_clr_i |=> rx_drop_o);
  // R7
  drop_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    host_wr_i && (rx_byte_vld_i || rx_eof_i) && !rx_prot_i |=> rx_drop_o);
  // R11
  drop_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_clr_i && !host_wr_i |=> !rx_drop_o);
  // R6
  prot_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_prot_i |=> $stable(rx_len_o));
  // R5
  len_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rx_eof_i |=> $stable(rx_len_o));
endmodule

bind pkt_buf_ctrl pb_chk #(.LW(LW)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .host_wr_i(host_wr_i), .host_rd_i(host_rd_i),
  .rx_byte_vld_i(rx_byte_vld_i), .rx_eof_i(rx_eof_i), .rx_prot_i(rx_prot_i),
  .tx_rd_i(tx_rd_i), .err_clr_i(err_clr_i), .rx_len_o(rx_len_o),
  .undr_o(undr_o), .rx_drop_o(rx_drop_o)
);

// File: tb/pkt_buf_ctrl_test.sv
module pkt_buf_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 128;

  logic clk = 0, rst_n = 0;
  logic host_start = 0, host_burst = 0, host_wr = 0, host_rd = 0;
  logic [6:0] host_addr = 0, tx_addr = 0;
  logic [7:0] host_wdata = 0, rx_byte = 0, rx_lqi = 0;
  logic rx_sof = 0, rx_byte_vld = 0, rx_eof = 0, rx_prot = 0, tx_rd = 0, err_clr = 0;
  logic [7:0] host_rdata, tx_rdata, rx_len;
  logic undr, rx_drop;

  always #(CLK_PERIOD/2) clk = ~clk;

  pkt_buf_ctrl uut (
    .clk_i(clk), .rst_ni(rst_n),
    .host_start_i(host_start), .host_addr_i(host_addr), .host_burst_i(host_burst),
    .host_wr_i(host_wr), .host_wdata_i(host_wdata), .host_rd_i(host_rd),
    .host_rdata_o(host_rdata),
    .rx_sof_i(rx_sof), .rx_byte_vld_i(rx_byte_vld), .rx_byte_i(rx_byte),
    .rx_eof_i(rx_eof), .rx_lqi_i(rx_lqi), .rx_prot_i(rx_prot), .rx_len_o(rx_len),
    .tx_rd_i(tx_rd), .tx_addr_i(tx_addr), .tx_rdata_o(tx_rdata),
    .err_clr_i(err_clr), .undr_o(undr), .rx_drop_o(rx_drop)
  );

  int n_chk = 0, n_fail = 0;
  string cur_req = "R1";
  bit done = 0;

  task automatic chk(string what, int act, int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", cur_req, what, act, exp);
    end
  endtask

  // reference model
  int mem[DEPTH];
  int m_len0, m_hptr, m_rptr, m_rcnt, m_rxlen, m_hrd, m_trd;
  bit m_seen, m_undr, m_drop;
  int heff, reff, ceff, wv;
  bit rtry, uset, dset;

  initial for (int i = 0; i < DEPTH; i++) mem[i] = -1;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_len0 = 0; m_hptr = 0; m_rptr = 0; m_rcnt = 0; m_rxlen = 0;
      m_hrd = 0; m_trd = 0; m_seen = 0; m_undr = 0; m_drop = 0;
    end else begin
      heff = host_start ? int'(host_addr) : m_hptr;
      reff = rx_sof ? 1 : m_rptr;
      ceff = rx_sof ? 0 : m_rcnt;
      rtry = (rx_byte_vld || rx_eof) && !rx_prot;
      uset = (tx_rd && int'(tx_addr) > m_len0) ||
             (host_rd && host_burst && m_seen && heff > m_rxlen + 1);
      dset = host_wr && rtry;
      if (host_rd) m_hrd = mem[heff];
      if (tx_rd) m_trd = mem[tx_addr];
      if (host_wr) begin
        mem[heff] = host_wdata;
        if (heff == 0) m_len0 = host_wdata;
      end else if (rtry) begin
        wv = rx_eof ? rx_lqi : rx_byte;
        mem[reff] = wv;
        if (reff == 0) m_len0 = wv;
      end
      if (uset) m_undr = 1; else if (err_clr) m_undr = 0;
      if (dset) m_drop = 1; else if (err_clr) m_drop = 0;
      if (rx_eof) begin
        m_rptr = reff; m_rcnt = ceff;
        if (!rx_prot) begin m_rxlen = ceff; m_seen = 1; end
      end else if (rx_byte_vld) begin
        m_rptr = (reff + 1) % DEPTH; m_rcnt = ceff + 1;
      end else if (rx_sof) begin
        m_rptr = 1; m_rcnt = 0;
      end
      if ((host_rd || host_wr) && host_burst) m_hptr = (heff + 1) % DEPTH;
      else if (host_start) m_hptr = host_addr;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("rx_len_o", rx_len, m_rxlen);
      chk("undr_o", undr, m_undr);
      chk("rx_drop_o", rx_drop, m_drop);
      if (m_hrd >= 0) chk("host_rdata_o", host_rdata, m_hrd);
      if (m_trd >= 0) chk("tx_rdata_o", tx_rdata, m_trd);
    end
  end

  task automatic step();
    @(negedge clk);
    host_start = 0; host_wr = 0; host_rd = 0; host_burst = 0;
    rx_sof = 0; rx_byte_vld = 0; rx_eof = 0; tx_rd = 0; err_clr = 0;
  endtask

  task automatic hwr(int a, int d, bit st, bit bu);
    host_start = st; host_addr = 7'(a); host_wdata = 8'(d); host_burst = bu; host_wr = 1;
    step();
  endtask

  task automatic hrd(int a, bit st, bit bu);
    host_start = st; host_addr = 7'(a); host_burst = bu; host_rd = 1;
    step();
  endtask

  task automatic txr(int a);
    tx_addr = 7'(a); tx_rd = 1;
    step();
  endtask

  task automatic rx_frame(int n, int base, int lqi);
    rx_sof = 1; step();
    for (int i = 0; i < n; i++) begin rx_byte = 8'(base + i); rx_byte_vld = 1; step(); end
    rx_lqi = 8'(lqi); rx_eof = 1; step();
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1
    chk("reset rx_len_o", rx_len, 0);
    chk("reset undr_o", undr, 0);
    chk("reset rx_drop_o", rx_drop, 0);
    chk("reset host_rdata_o", host_rdata, 0);
    step();

    // R2 single access, pointer held
    cur_req = "R2";
    hwr(5, 8'h3C, 1, 0);
    hwr(9, 8'h81, 1, 0);
    hwr(20, 8'h11, 1, 0);
    hwr(0, 8'h22, 0, 0);
    hrd(5, 1, 0);  chk("single read 5", host_rdata, 8'h3C);
    hrd(20, 1, 0); chk("held pointer 20", host_rdata, 8'h22);
    hrd(0, 0, 0);  chk("repeat read 20", host_rdata, 8'h22);
    hrd(9, 1, 0);  chk("single read 9", host_rdata, 8'h81);

    // R3 full-buffer burst, then wrap
    cur_req = "R3";
    for (int i = 0; i < DEPTH; i++) hwr(0, (i * 7 + 3) & 255, i == 0, 1);
    for (int i = 0; i < DEPTH; i++) begin
      hrd(0, i == 0, 1);
      chk("burst read", host_rdata, (i * 7 + 3) & 255);
    end
    for (int i = 0; i < 4; i++) hwr(126, 8'hE0 + i, i == 0, 1);
    hrd(126, 1, 1); chk("wrap 126", host_rdata, 8'hE0);
    hrd(0, 0, 1);   chk("wrap 127", host_rdata, 8'hE1);
    hrd(0, 0, 1);   chk("wrap 0", host_rdata, 8'hE2);
    hrd(0, 0, 1);   chk("wrap 1", host_rdata, 8'hE3);

    // R8 / R9 transmit port
    cur_req = "R8";
    hwr(0, 10, 1, 0);
    txr(3);  chk("tx byte 3", tx_rdata, 24);
    txr(10); chk("tx byte 10", tx_rdata, 73);
    cur_req = "R9";
    for (int i = 0; i <= 10; i++) txr(i);
    chk("no underrun at length", undr, 0);
    txr(11); chk("underrun past length", undr, 1);
    cur_req = "R11";
    err_clr = 1; tx_addr = 12; tx_rd = 1; step();
    chk("set beats clear", undr, 1);
    err_clr = 1; step();
    chk("clear", undr, 0);

    // R4 / R5 short frame
    cur_req = "R4";
    rx_frame(6, 8'h40, 8'hA5);
    cur_req = "R5";
    chk("rx length", rx_len, 6);
    hrd(1, 1, 1); chk("payload at 1", host_rdata, 8'h40);
    cur_req = "R4";
    for (int i = 1; i < 6; i++) begin hrd(0, 0, 1); chk("payload", host_rdata, 8'h40 + i); end
    cur_req = "R5";
    hrd(0, 0, 1); chk("lqi at len+1", host_rdata, 8'hA5);
    cur_req = "R10";
    chk("no underrun within frame", undr, 0);
    hrd(0, 0, 1); chk("burst past frame", undr, 1);
    err_clr = 1; step();
    hrd(30, 1, 0); chk("single read no underrun", undr, 0);

    // R6 protect
    cur_req = "R6";
    rx_prot = 1;
    rx_sof = 1; step();
    rx_byte = 8'h55; rx_byte_vld = 1; step();
    hwr(2, 8'hC7, 1, 0);
    rx_byte_vld = 1; step();
    rx_lqi = 8'h66; rx_eof = 1; step();
    rx_prot = 0;
    chk("length held", rx_len, 6);
    chk("no drop", rx_drop, 0);
    hrd(1, 1, 0); chk("byte 1 kept", host_rdata, 8'h40);
    hrd(2, 1, 0); chk("host write landed", host_rdata, 8'hC7);

    // R7 collision
    cur_req = "R7";
    rx_sof = 1; step();
    rx_byte = 8'h71; rx_byte_vld = 1; step();
    rx_byte = 8'h72; rx_byte_vld = 1;
    host_start = 1; host_addr = 40; host_wdata = 8'h99; host_wr = 1; step();
    chk("drop flagged", rx_drop, 1);
    rx_lqi = 8'h33; rx_eof = 1; step();
    chk("drop sticky", rx_drop, 1);
    chk("length 2", rx_len, 2);
    hrd(2, 1, 0);  chk("rx byte lost", host_rdata, 8'hC7);
    hrd(40, 1, 0); chk("host byte kept", host_rdata, 8'h99);
    hrd(3, 1, 0);  chk("lqi at 3", host_rdata, 8'h33);
    cur_req = "R11";
    err_clr = 1; step();
    chk("drop cleared", rx_drop, 0);

    // R5 max frame wraps lqi to 0, feeds R9
    cur_req = "R5";
    rx_frame(127, 8'h01, 8'h5A);
    chk("length 127", rx_len, 127);
    hrd(0, 1, 0);   chk("lqi wrapped to 0", host_rdata, 8'h5A);
    hrd(127, 1, 0); chk("last payload", host_rdata, 8'h7F);
    cur_req = "R9";
    txr(90); chk("tx at new length", undr, 0);
    txr(91); chk("tx past new length", undr, 1);
    step();

    done = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end
endmodule